// File: doc/BRIEF.md
# Boost Fault Supervisor

This block supervises the reverse (boost) mode of a single-cell charger, in which the battery is stepped up to feed the input rail. A host sets or clears a boost enable bit through a write strobe. The block then starts the converter and watches the output rise. It passes to regulation, and at light load it parks the converter in burst pauses. Five digitized comparator signals are watched throughout: input-side overvoltage, current-limit hit, output within 1 V of the battery, battery undervoltage and watchdog expiry.

On any fault the converter is stopped and the enable bit drops. A 3-bit fault code is stored and a single-cycle event is raised for a downstream interrupt pulse generator. The converter then stays off until the host writes the enable bit to 1 again. Every time window counts ticks of a clock-enable input. The window lengths are parameters: the defaults stand for 8 ms at a 1 µs tick, and a short value is used in simulation.

Top module: `boost_fault_sup`

## Requirements
- R1: After reset, boost_en, conv_run, fault_event and fault_code are all 0.
- R2: A host write of 1 while stopped sets boost_en and conv_run on the next edge and clears fault_code to 0. A host write of 0 while active stops the converter without a fault event and leaves fault_code unchanged.
- R3: If out_ok_in stays low for WIN_TICKS consecutive ticks of the startup phase, the block stops with fault_code 3'b011 (overcurrent). out_ok_in high during startup moves the block to regulation.
- R4: ilim_in high during WIN_TICKS consecutive ticks while active is an overload fault with code 3'b011. A low cycle restarts the count, and shorter events cause no fault.
- R5: ovp_in high during OVP_DGL_TICKS consecutive ticks while active is a fault with code 3'b001 (overvoltage).
- R6: bat_low_in high while active stops the converter on the next edge with code 3'b010 (low supply).
- R7: wdog_exp_in high while active stops the converter with code 3'b010, the low-supply code.
- R8: When several faults fall on one edge, only the highest is stored, in the order overcurrent (3'b011), overvoltage (3'b001), low supply (3'b010).
- R9: On each fault, fault_event is high for exactly one cycle. boost_en clears and fault_code updates on that same edge.
- R10: After a fault, boost_en stays 0 whatever the comparators do until a host write of 1. A fault beats a host write made in the same cycle.
- R11: In regulation, min_duty_in together with burst_hi_in pauses switching (conv_run 0, boost_en still 1). burst_lo_in during the pause resumes switching.
- R12: While stopped, the comparator inputs have no effect: no event, and fault_code is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Clock-enable tick for the timing windows |
| host_wr | input | 1 | Host write strobe for the enable bit |
| host_wdata | input | 1 | Value written to the enable bit |
| ovp_in | input | 1 | Input-side overvoltage comparator |
| ilim_in | input | 1 | Cycle-by-cycle current-limit hit |
| out_ok_in | input | 1 | Output is within 1 V of the battery |
| bat_low_in | input | 1 | Battery below the undervoltage threshold |
| wdog_exp_in | input | 1 | Watchdog expiry |
| min_duty_in | input | 1 | Converter at minimum duty cycle |
| burst_hi_in | input | 1 | Output above the burst-entry level |
| burst_lo_in | input | 1 | Output at or below the burst-exit level |
| boost_en | output | 1 | Boost enable bit |
| conv_run | output | 1 | Converter switching enable |
| fault_code | output | 3 | Last fault code |
| fault_event | output | 1 | One-cycle fault notification |

## Verification
A fault can fall on the same edge as a host write. Several fault sources can also trip on one edge. Both cases are built by directed sequences. In one, a current-limit run is stretched so that the overload window, the overvoltage deglitch and a battery undervoltage all expire on a single edge, and the check is that only 3'b011 is stored. In another, a host write is issued on the edge where a battery undervoltage arrives, and the check is that the fault wins. Random stimulus with sticky comparator levels and irregular ticks repeats these collisions, and every cycle is compared with a bench model of the requirements.

// File: rtl/bstsup_pkg.sv
package bstsup_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_RUN   = 2'd2,
      ST_PAUSE = 2'd3
   } bst_state_e;

   typedef enum logic [2:0] {
      FC_NONE     = 3'd0,
      FC_OVERVOLT = 3'd1,
      FC_LOWSUP   = 3'd2,
      FC_OVERCUR  = 3'd3
   } fault_code_e;

   typedef struct packed {
      logic overcur;
      logic overvolt;
      logic lowbat;
      logic wdog;
   } fault_vec_t;

endpackage

// File: rtl/bstsup_persist.sv
// Persistence window: trip fires when cond has been high on TICKS
// consecutive ticks while armed. TICKS of 0 makes the check immediate.
module bstsup_persist #(
   parameter int unsigned TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic cond,
   input  logic tick,
   output logic trip
);

   generate
      if (TICKS == 0) begin : g_direct
         assign trip = arm & cond;
      end else begin : g_count
         localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS);
         localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

         logic [CW-1:0] cnt_q;
         logic          live;

         assign live = arm & cond;
         assign trip = live & tick & (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!live) begin
               cnt_q <= '0;
            end else if (tick && (cnt_q != LAST)) begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bstsup_fault_arb.sv
// Fixed-priority fault selection: overcurrent, overvoltage, low supply.
module bstsup_fault_arb
   import bstsup_pkg::*;
(
   input  fault_vec_t  req,
   output logic        any,
   output fault_code_e code
);

   always_comb begin
      any  = req.overcur | req.overvolt | req.lowbat | req.wdog;
      code = FC_NONE;
      if (req.overcur) begin
         code = FC_OVERCUR;
      end else if (req.overvolt) begin
         code = FC_OVERVOLT;
      end else if (req.lowbat || req.wdog) begin
         code = FC_LOWSUP;
      end
   end

endmodule

// File: rtl/bstsup_mode_fsm.sv
module bstsup_mode_fsm
   import bstsup_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic        host_wdata,
   input  logic        flt_any,
   input  fault_code_e flt_code,
   input  logic        out_ok,
   input  logic        min_duty,
   input  logic        burst_hi,
   input  logic        burst_lo,
   output bst_state_e  state,
   output logic        en_q,
   output logic        run_q,
   output fault_code_e code_q,
   output logic        evt_q
);

   bst_state_e  st_n;
   logic        en_n;
   fault_code_e code_n;
   logic        evt_n;

   always_comb begin
      st_n   = state;
      en_n   = en_q;
      code_n = code_q;
      evt_n  = 1'b0;
      if (state == ST_IDLE) begin
         if (host_wr && host_wdata) begin
            st_n   = ST_START;
            en_n   = 1'b1;
            code_n = FC_NONE;
         end
      end else if (flt_any) begin
         st_n   = ST_IDLE;
         en_n   = 1'b0;
         code_n = flt_code;
         evt_n  = 1'b1;
      end else if (host_wr && !host_wdata) begin
         st_n = ST_IDLE;
         en_n = 1'b0;
      end else begin
         unique case (state)
            ST_START: if (out_ok) st_n = ST_RUN;
            ST_RUN:   if (min_duty && burst_hi) st_n = ST_PAUSE;
            ST_PAUSE: if (burst_lo) st_n = ST_RUN;
            default:  st_n = state;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         en_q   <= 1'b0;
         run_q  <= 1'b0;
         code_q <= FC_NONE;
         evt_q  <= 1'b0;
      end else begin
         state  <= st_n;
         en_q   <= en_n;
         run_q  <= (st_n == ST_START) || (st_n == ST_RUN);
         code_q <= code_n;
         evt_q  <= evt_n;
      end
   end

endmodule

// File: rtl/boost_fault_sup.sv
module boost_fault_sup
   import bstsup_pkg::*;
#(
   parameter int unsigned WIN_TICKS     = 8000,
   parameter int unsigned OVP_DGL_TICKS = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       host_wr,
   input  logic       host_wdata,
   input  logic       ovp_in,
   input  logic       ilim_in,
   input  logic       out_ok_in,
   input  logic       bat_low_in,
   input  logic       wdog_exp_in,
   input  logic       min_duty_in,
   input  logic       burst_hi_in,
   input  logic       burst_lo_in,
   output logic       boost_en,
   output logic       conv_run,
   output logic [2:0] fault_code,
   output logic       fault_event
);

   generate
      if (WIN_TICKS < 1) begin : g_bad_win
         $error("WIN_TICKS must be at least 1");
      end
   endgenerate

   bst_state_e  state;
   fault_code_e code_q;
   fault_code_e arb_code;
   fault_vec_t  req;
   logic        active;
   logic        starting;
   logic        trip_ovl;
   logic        trip_ovp;
   logic        trip_start;
   logic        flt_any;

   assign active   = (state != ST_IDLE);
   assign starting = (state == ST_START);

   bstsup_persist #(.TICKS(WIN_TICKS)) u_ovl (
      .clk(clk), .rst_n(rst_n), .arm(active), .cond(ilim_in),
      .tick(tick_en), .trip(trip_ovl)
   );

   bstsup_persist #(.TICKS(OVP_DGL_TICKS)) u_ovp (
      .clk(clk), .rst_n(rst_n), .arm(active), .cond(ovp_in),
      .tick(tick_en), .trip(trip_ovp)
   );

   bstsup_persist #(.TICKS(WIN_TICKS)) u_start (
      .clk(clk), .rst_n(rst_n), .arm(starting), .cond(!out_ok_in),
      .tick(tick_en), .trip(trip_start)
   );

   always_comb begin
      req.overcur  = trip_ovl | trip_start;
      req.overvolt = trip_ovp;
      req.lowbat   = active & bat_low_in;
      req.wdog     = active & wdog_exp_in;
   end

   bstsup_fault_arb u_arb (
      .req(req), .any(flt_any), .code(arb_code)
   );

   bstsup_mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .flt_any(flt_any), .flt_code(arb_code), .out_ok(out_ok_in),
      .min_duty(min_duty_in), .burst_hi(burst_hi_in), .burst_lo(burst_lo_in),
      .state(state), .en_q(boost_en), .run_q(conv_run), .code_q(code_q),
      .evt_q(fault_event)
   );

   assign fault_code = code_q;

endmodule

// File: rtl/boost_fault_sup_chk.sv
module boost_fault_sup_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       host_wr,
   input logic       host_wdata,
   input logic       bat_low_in,
   input logic       boost_en,
   input logic       conv_run,
   input logic [2:0] fault_code,
   input logic       fault_event
);

   a_r9_event_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      fault_event |=> !fault_event);

   a_r9_event_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
      fault_event |-> !boost_en);

   a_r8_event_has_code: assert property (@(posedge clk) disable iff (!rst_n)
      fault_event |-> (fault_code != 3'd0));

   a_r10_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!boost_en && !(host_wr && host_wdata)) |=> !boost_en);

   a_r2_run_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      conv_run |-> boost_en);

   a_r6_lowbat_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (boost_en && bat_low_in) |=> (!boost_en && !conv_run));

   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !boost_en |=> !fault_event);

endmodule

bind boost_fault_sup boost_fault_sup_chk u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
   .bat_low_in(bat_low_in), .boost_en(boost_en), .conv_run(conv_run),
   .fault_code(fault_code), .fault_event(fault_event)
);

// File: tb/boost_fault_sup_tb.sv
`timescale 1ns/1ps
module boost_fault_sup_tb;

   localparam int WIN = 8;
   localparam int DGL = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b1, host_wr = 1'b0, host_wdata = 1'b0;
   logic ovp_in = 1'b0, ilim_in = 1'b0, out_ok_in = 1'b0, bat_low_in = 1'b0;
   logic wdog_exp_in = 1'b0, min_duty_in = 1'b0, burst_hi_in = 1'b0, burst_lo_in = 1'b0;
   logic boost_en, conv_run, fault_event;
   logic [2:0] fault_code;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // model of the requirements
   int m_st;
   bit m_en, m_run, m_evt;
   int m_code;
   int c_ovl, c_ovp, c_st;

   always #2.5 clk = ~clk;

   boost_fault_sup #(.WIN_TICKS(WIN), .OVP_DGL_TICKS(DGL)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .host_wr(host_wr),
      .host_wdata(host_wdata), .ovp_in(ovp_in), .ilim_in(ilim_in),
      .out_ok_in(out_ok_in), .bat_low_in(bat_low_in), .wdog_exp_in(wdog_exp_in),
      .min_duty_in(min_duty_in), .burst_hi_in(burst_hi_in), .burst_lo_in(burst_lo_in),
      .boost_en(boost_en), .conv_run(conv_run), .fault_code(fault_code),
      .fault_event(fault_event)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int prio_code(bit oc, bit ov, bit lb, bit wd);
      if (oc) return 3;
      if (ov) return 1;
      if (lb || wd) return 2;
      return 0;
   endfunction

   function automatic int next_cnt(bit live, bit tk, int cnt, int lim);
      if (!live) return 0;
      if (tk && cnt != lim - 1) return cnt + 1;
      return cnt;
   endfunction

   task automatic model_reset();
      m_st = 0; m_en = 0; m_run = 0; m_evt = 0; m_code = 0;
      c_ovl = 0; c_ovp = 0; c_st = 0;
   endtask

   task automatic model_edge();
      bit act, t_ovl, t_ovp, t_st, any;
      int code, nst;
      act   = (m_st != 0);
      t_ovl = act && ilim_in && tick_en && (c_ovl == WIN - 1);
      t_ovp = act && ovp_in && tick_en && (c_ovp == DGL - 1);
      t_st  = (m_st == 1) && !out_ok_in && tick_en && (c_st == WIN - 1);
      code  = prio_code(t_ovl || t_st, t_ovp, act && bat_low_in, act && wdog_exp_in);
      any   = (code != 0);
      c_ovl = next_cnt(act && ilim_in, tick_en, c_ovl, WIN);
      c_ovp = next_cnt(act && ovp_in, tick_en, c_ovp, DGL);
      c_st  = next_cnt((m_st == 1) && !out_ok_in, tick_en, c_st, WIN);
      nst   = m_st;
      m_evt = 0;
      if (m_st == 0) begin
         if (host_wr && host_wdata) begin nst = 1; m_en = 1; m_code = 0; end
      end else if (any) begin
         nst = 0; m_en = 0; m_code = code; m_evt = 1;
      end else if (host_wr && !host_wdata) begin
         nst = 0; m_en = 0;
      end else if (m_st == 1 && out_ok_in) nst = 2;
      else if (m_st == 2 && min_duty_in && burst_hi_in) nst = 3;
      else if (m_st == 3 && burst_lo_in) nst = 2;
      m_st  = nst;
      m_run = (nst == 1) || (nst == 2);
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk("R10 boost_en model", boost_en, m_en);
      chk("R11 conv_run model", conv_run, m_run);
      chk("R8 fault_code model", fault_code, m_code);
      chk("R9 fault_event model", fault_event, m_evt);
      host_wr = 1'b0;
   endtask

   task automatic quiet();
      ovp_in = 0; ilim_in = 0; bat_low_in = 0; wdog_exp_in = 0;
      min_duty_in = 0; burst_hi_in = 0; burst_lo_in = 0; tick_en = 1;
   endtask

   task automatic hwrite(bit v);
      host_wr = 1'b1; host_wdata = v;
      step();
   endtask

   task automatic start_run();
      out_ok_in = 1'b1;
      hwrite(1'b1);
      step();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1 boost_en reset", boost_en, 0);
      chk("R1 conv_run reset", conv_run, 0);
      chk("R1 fault_code reset", fault_code, 0);
      chk("R1 fault_event reset", fault_event, 0);
      rst_n = 1'b1;
      step();

      // R2 start and plain stop
      start_run();
      chk("R2 run after enable", conv_run, 1);
      chk("R2 enable set", boost_en, 1);
      hwrite(1'b0);
      chk("R2 stop no event", fault_event, 0);
      chk("R2 stop enable", boost_en, 0);

      // R3 startup timeout
      out_ok_in = 0;
      hwrite(1'b1);
      repeat (WIN - 1) step();
      chk("R3 still starting", boost_en, 1);
      step();
      chk("R3 timeout code", fault_code, 3);
      chk("R3 timeout event", fault_event, 1);
      step();
      chk("R9 event single cycle", fault_event, 0);

      // R4 overload persistence
      start_run();
      ilim_in = 1; repeat (WIN - 1) step();
      ilim_in = 0; step();
      ilim_in = 1; repeat (WIN - 1) step();
      chk("R4 short overload ignored", boost_en, 1);
      step();
      chk("R4 overload code", fault_code, 3);
      chk("R4 overload enable", boost_en, 0);
      quiet();

      // R5 overvoltage deglitch
      start_run();
      ovp_in = 1; repeat (DGL - 1) step();
      chk("R5 before deglitch", boost_en, 1);
      step();
      chk("R5 overvoltage code", fault_code, 1);
      quiet();

      // R6 battery undervoltage
      start_run();
      bat_low_in = 1; step();
      chk("R6 lowbat code", fault_code, 2);
      chk("R6 lowbat stop", conv_run, 0);
      quiet();

      // R7 watchdog
      start_run();
      wdog_exp_in = 1; step();
      chk("R7 watchdog code", fault_code, 2);
      chk("R7 watchdog event", fault_event, 1);
      quiet();

      // R8 priority: all three trip on one edge
      start_run();
      ilim_in = 1; repeat (WIN - DGL) step();
      ovp_in = 1; repeat (DGL - 1) step();
      bat_low_in = 1; step();
      chk("R8 overcurrent wins", fault_code, 3);
      quiet();
      start_run();
      ovp_in = 1; repeat (DGL - 1) step();
      bat_low_in = 1; wdog_exp_in = 1; step();
      chk("R8 overvoltage over low supply", fault_code, 1);
      quiet();

      // R10 fault beats host write, latched off
      start_run();
      bat_low_in = 1; hwrite(1'b1);
      chk("R10 fault wins write", boost_en, 0);
      chk("R10 fault event on write", fault_event, 1);
      bat_low_in = 0; repeat (4) step();
      chk("R10 stays off", boost_en, 0);
      chk("R10 run stays off", conv_run, 0);
      hwrite(1'b1);
      chk("R10 rewrite restarts", boost_en, 1);
      chk("R2 code cleared", fault_code, 0);
      step();

      // R11 burst pause and resume
      min_duty_in = 1; burst_hi_in = 1; step();
      min_duty_in = 0; burst_hi_in = 0;
      chk("R11 paused", conv_run, 0);
      chk("R11 enable kept", boost_en, 1);
      repeat (3) step();
      chk("R11 pause held", conv_run, 0);
      burst_lo_in = 1; step(); burst_lo_in = 0;
      chk("R11 resumed", conv_run, 1);

      // R12 idle ignores comparators
      wdog_exp_in = 1; step(); quiet();
      ovp_in = 1; ilim_in = 1; bat_low_in = 1; wdog_exp_in = 1; out_ok_in = 0;
      repeat (WIN + 2) step();
      chk("R12 idle no event", fault_event, 0);
      chk("R12 idle code kept", fault_code, 2);
      chk("R12 idle enable", boost_en, 0);
      quiet();

      // constrained random phase
      for (int i = 0; i < 4000; i++) begin
         tick_en     = ($urandom % 2) == 0;
         ovp_in      = ovp_in  ? (($urandom % 10) < 8) : (($urandom % 100) < 3);
         ilim_in     = ilim_in ? (($urandom % 10) < 9) : (($urandom % 100) < 4);
         out_ok_in   = ($urandom % 10) < 3;
         bat_low_in  = ($urandom % 200) == 0;
         wdog_exp_in = ($urandom % 200) == 0;
         min_duty_in = ($urandom % 5) == 0;
         burst_hi_in = ($urandom % 5) == 0;
         burst_lo_in = ($urandom % 5) == 0;
         if (!m_en) begin
            host_wr = ($urandom % 8) == 0;
            host_wdata = ($urandom % 4) != 0;
         end else begin
            host_wr = ($urandom % 64) == 0;
            host_wdata = $urandom % 2;
         end
         step();
      end

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule